// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns one interrupt delivery request into the set of local interrupt units that should receive it. A request carries an 8-bit destination, a bit choosing physical or logical addressing, a 2-bit shorthand, a 3-bit delivery mode and the index of the sending unit. Each of up to `NUM_UNITS` units describes itself with an 8-bit ID, an 8-bit logical destination, a 4-bit format model and a presence bit. The resolver compares the request against every unit in parallel and applies the shorthand. It then drops absent units. For lowest-priority delivery it keeps only the lowest-indexed candidate.

The result is registered. It appears one cycle after the request strobe, together with a single-cycle valid pulse, and stays on the mask output until the next request. Arbitration by processor priority and the delivery actions themselves belong to other blocks.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_mask` is all zeros.
- R2: A request sampled with `req_valid` high gives `out_valid` high in the next cycle only. `out_mask` carries that request's result from that cycle and keeps it until the next request.
- R3: With shorthand 0 and `req_logical` = 0, destination 8'hFF selects every present unit.
- R4: With shorthand 0 and `req_logical` = 0, any destination other than 8'hFF selects each present unit whose ID equals it. If no unit matches, the mask is empty.
- R5: With shorthand 0 and `req_logical` = 1, a unit whose format model is 4'hF (flat) is selected when destination AND its logical destination is nonzero.
- R6: With shorthand 0 and `req_logical` = 1, a unit whose format model is 4'h0 (cluster) is selected when both of these hold: bits [7:4] of the destination equal bits [7:4] of its logical destination, and bits [3:0] of the two share a set bit.
- R7: In logical mode, a unit whose format model is neither 4'hF nor 4'h0 is never selected.
- R8: `req_short` selects the targets as follows. Value 1 selects only the unit at `req_src`. Value 2 selects all units. Value 3 selects all units except `req_src`. Value 0 uses the destination matching of R3 to R7.
- R9: When `req_mode` is 3'b001 (lowest priority), only the lowest-indexed bit of the mask stays set. Other mode values leave the mask unchanged.
- R10: A unit whose `unit_present` bit is 0 is never selected, under any shorthand, broadcast or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 0 = physical, 1 = logical addressing |
| req_short | input | 2 | Shorthand: 0 none, 1 self, 2 all, 3 all but self |
| req_mode | input | 3 | Delivery mode; 3'b001 is lowest priority |
| req_src | input | $clog2(NUM_UNITS) | Index of the sending unit |
| unit_present | input | NUM_UNITS | Presence bit per unit |
| unit_id | input | 8*NUM_UNITS | IDs, unit i in bits [8i+7:8i] |
| unit_ldest | input | 8*NUM_UNITS | Logical destinations, unit i in bits [8i+7:8i] |
| unit_fmt | input | 4*NUM_UNITS | Format models, unit i in bits [4i+3:4i] |
| out_valid | output | 1 | Result pulse, one cycle after the request |
| out_mask | output | NUM_UNITS | Registered target mask |

## Verification
The hardest case to reach is a destination that hits a chosen unit. With random IDs, a random 8-bit destination almost never equals any of them. Cluster matching needs equal upper nibbles and overlapping lower nibbles at the same time, which random values also rarely give. The stimulus therefore often copies the destination from a randomly chosen unit's ID or logical destination, and draws format models mostly from the two legal values. Directed requests add an absent sender under the self shorthand and a lowest-priority request whose candidate set is empty.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
   typedef enum logic [1:0] {
      SH_NONE   = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;

   localparam logic [2:0] DM_LOWPRI   = 3'b001;
   localparam logic [3:0] FMT_FLAT    = 4'hF;
   localparam logic [3:0] FMT_CLUSTER = 4'h0;
   localparam logic [7:0] DEST_BCAST  = 8'hFF;
   localparam int         ID_W        = 8;
   localparam int         FMT_W       = 4;
endpackage

// File: rtl/irq_unit_match.sv
module irq_unit_match
   import irq_dest_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ID_W-1:0]  dest,
   input  logic             logical,
   input  logic [ID_W-1:0]  id,
   input  logic [ID_W-1:0]  ldest,
   input  logic [FMT_W-1:0] fmt,
   output logic             hit
);
   logic phys_hit;
   logic flat_hit;
   logic clus_hit;
   logic log_hit;

   always_comb begin
      phys_hit = (dest == DEST_BCAST) || (dest == id);
      flat_hit = |(dest & ldest);
      clus_hit = (dest[7:4] == ldest[7:4]) && (|(dest[3:0] & ldest[3:0]));
      case (fmt)
         FMT_FLAT:    log_hit = flat_hit;
         FMT_CLUSTER: log_hit = clus_hit;
         default:     log_hit = 1'b0;
      endcase
      hit = logical ? log_hit : phys_hit;
   end

   AST_ODD_FORMAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (logical && fmt != FMT_FLAT && fmt != FMT_CLUSTER) |-> !hit); // R7
   AST_PHYS_BCAST_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!logical && dest == DEST_BCAST) |-> hit); // R3
endmodule

// File: rtl/irq_shorthand_sel.sv
module irq_shorthand_sel
   import irq_dest_pkg::*;
#(
   parameter int NUM_UNITS = 16,
   localparam int IDX_W = $clog2(NUM_UNITS)
)(
   input  logic [NUM_UNITS-1:0] dest_hits,
   input  logic [1:0]           short_sel,
   input  logic [IDX_W-1:0]     src,
   input  logic [NUM_UNITS-1:0] present,
   output logic [NUM_UNITS-1:0] mask
);
   logic [NUM_UNITS-1:0] self_oh;
   logic [NUM_UNITS-1:0] chosen;

   always_comb begin
      self_oh = '0;
      self_oh[src] = 1'b1;
      case (shorthand_e'(short_sel))
         SH_NONE:   chosen = dest_hits;
         SH_SELF:   chosen = self_oh;
         SH_ALL:    chosen = '1;
         SH_OTHERS: chosen = ~self_oh;
         default:   chosen = '0;
      endcase
      mask = chosen & present;
   end
endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
   parameter int NUM_UNITS  = 16,
   parameter int PICK_STYLE = 0
)(
   input  logic [NUM_UNITS-1:0] cand,
   input  logic                 enable,
   output logic [NUM_UNITS-1:0] picked
);
   logic [NUM_UNITS-1:0] lowest;

   generate
      if (PICK_STYLE == 0) begin : g_arith
         always_comb lowest = cand & (~cand + 1'b1);
      end else begin : g_chain
         always_comb begin
            logic seen;
            seen = 1'b0;
            lowest = '0;
            for (int i = 0; i < NUM_UNITS; i++) begin
               if (cand[i] && !seen) begin
                  lowest[i] = 1'b1;
                  seen = 1'b1;
               end
            end
         end
      end
   endgenerate

   assign picked = enable ? lowest : cand;
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
   import irq_dest_pkg::*;
#(
   parameter int NUM_UNITS  = 16,
   parameter int PICK_STYLE = 0,
   localparam int IDX_W = $clog2(NUM_UNITS)
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [7:0]                 req_dest,
   input  logic                       req_logical,
   input  logic [1:0]                 req_short,
   input  logic [2:0]                 req_mode,
   input  logic [IDX_W-1:0]           req_src,
   input  logic [NUM_UNITS-1:0]       unit_present,
   input  logic [ID_W*NUM_UNITS-1:0]  unit_id,
   input  logic [ID_W*NUM_UNITS-1:0]  unit_ldest,
   input  logic [FMT_W*NUM_UNITS-1:0] unit_fmt,
   output logic                       out_valid,
   output logic [NUM_UNITS-1:0]       out_mask
);
   initial begin
      assert (NUM_UNITS >= 2 && NUM_UNITS <= 256)
         else $error("NUM_UNITS out of range");
      assert (PICK_STYLE == 0 || PICK_STYLE == 1)
         else $error("PICK_STYLE must be 0 or 1");
   end

   logic [NUM_UNITS-1:0] dest_hits;
   logic [NUM_UNITS-1:0] sel_mask;
   logic [NUM_UNITS-1:0] final_mask;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_UNITS; gi++) begin : g_unit
         irq_unit_match u_match (
            .clk     (clk),
            .rst_n   (rst_n),
            .dest    (req_dest),
            .logical (req_logical),
            .id      (unit_id[gi*ID_W +: ID_W]),
            .ldest   (unit_ldest[gi*ID_W +: ID_W]),
            .fmt     (unit_fmt[gi*FMT_W +: FMT_W]),
            .hit     (dest_hits[gi])
         );
      end
   endgenerate

   irq_shorthand_sel #(.NUM_UNITS(NUM_UNITS)) u_short (
      .dest_hits (dest_hits),
      .short_sel (req_short),
      .src       (req_src),
      .present   (unit_present),
      .mask      (sel_mask)
   );

   irq_first_pick #(.NUM_UNITS(NUM_UNITS), .PICK_STYLE(PICK_STYLE)) u_pick (
      .cand   (sel_mask),
      .enable (req_mode == DM_LOWPRI),
      .picked (final_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mask  <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) out_mask <= final_mask;
      end
   end

   AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid); // R2
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid); // R2
   AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(out_mask)); // R2
   AST_ABSENT_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ((out_mask & ~$past(unit_present)) == '0)); // R10
   AST_LOWPRI_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == DM_LOWPRI) |=> $onehot0(out_mask)); // R9
   AST_SELF_ONLY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_short == 2'd1) |=> ($countones(out_mask) <= 1)); // R8
endmodule

// File: tb/irq_dest_resolver_test.sv
`timescale 1ns/1ps
module irq_dest_resolver_test;
   localparam int N = 16;
   localparam int IW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [7:0] req_dest = '0;
   logic req_logical = 1'b0;
   logic [1:0] req_short = '0;
   logic [2:0] req_mode = '0;
   logic [IW-1:0] req_src = '0;
   logic [N-1:0] unit_present = '1;
   logic [8*N-1:0] unit_id;
   logic [8*N-1:0] unit_ldest;
   logic [4*N-1:0] unit_fmt;
   logic out_valid;
   logic [N-1:0] out_mask;

   logic [7:0] cfg_id [N];
   logic [7:0] cfg_ld [N];
   logic [3:0] cfg_fmt [N];

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         unit_id[i*8 +: 8]    = cfg_id[i];
         unit_ldest[i*8 +: 8] = cfg_ld[i];
         unit_fmt[i*4 +: 4]   = cfg_fmt[i];
      end
   end

   irq_dest_resolver #(.NUM_UNITS(N)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
      .req_logical(req_logical), .req_short(req_short), .req_mode(req_mode),
      .req_src(req_src), .unit_present(unit_present), .unit_id(unit_id),
      .unit_ldest(unit_ldest), .unit_fmt(unit_fmt), .out_valid(out_valid),
      .out_mask(out_mask)
   );

   function automatic logic [N-1:0] model(input logic [7:0] d, input logic lg,
         input logic [1:0] sh, input logic [2:0] m, input int s);
      logic [N-1:0] r;
      logic [N-1:0] hits;
      hits = '0;
      for (int i = 0; i < N; i++) begin
         if (!lg) hits[i] = (d == 8'hFF) || (d == cfg_id[i]);
         else if (cfg_fmt[i] == 4'hF) hits[i] = (d & cfg_ld[i]) != 0;
         else if (cfg_fmt[i] == 4'h0)
            hits[i] = (d[7:4] == cfg_ld[i][7:4]) && ((d[3:0] & cfg_ld[i][3:0]) != 0);
      end
      case (sh)
         2'd0: r = hits;
         2'd1: begin r = '0; r[s] = 1'b1; end
         2'd2: r = '1;
         default: begin r = '1; r[s] = 1'b0; end
      endcase
      r = r & unit_present;
      if (m == 3'b001) begin
         logic [N-1:0] t;
         t = '0;
         for (int i = N - 1; i >= 0; i--) if (r[i]) t = '0 | (N'(1) << i);
         r = t;
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_req(input string tag, input logic [7:0] d, input logic lg,
         input logic [1:0] sh, input logic [2:0] m, input int s);
      logic [N-1:0] exp;
      @(negedge clk);
      req_dest = d; req_logical = lg; req_short = sh; req_mode = m;
      req_src = IW'(s); req_valid = 1'b1;
      exp = model(d, lg, sh, m, s);
      @(posedge clk); #1;
      check({tag, " R2 valid"}, N'(out_valid), N'(1));
      check(tag, out_mask, exp);
      @(negedge clk);
      req_valid = 1'b0;
      req_dest = 8'($urandom); req_short = 2'($urandom); req_mode = 3'($urandom);
      @(posedge clk); #1;
      check("R2 valid drops", N'(out_valid), N'(0));
      check("R2 mask holds", out_mask, exp);
   endtask

   task automatic rand_cfg();
      for (int i = 0; i < N; i++) begin
         cfg_id[i] = 8'($urandom);
         cfg_ld[i] = 8'($urandom);
         case ($urandom % 5)
            0, 1: cfg_fmt[i] = 4'hF;
            2, 3: cfg_fmt[i] = 4'h0;
            default: cfg_fmt[i] = 4'($urandom);
         endcase
      end
      unit_present = N'($urandom) | N'($urandom) | N'($urandom);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      for (int i = 0; i < N; i++) begin
         cfg_id[i] = 8'(i + 8'h20); cfg_ld[i] = 8'(1 << (i % 8)); cfg_fmt[i] = 4'hF;
      end
      #1;
      check("R1 valid at reset", N'(out_valid), N'(0));
      check("R1 mask at reset", out_mask, '0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 valid after reset", N'(out_valid), N'(0));

      unit_present = 16'hFF7F;
      do_req("R3 R10 broadcast", 8'hFF, 1'b0, 2'd0, 3'd0, 0);
      do_req("R4 id match", 8'h25, 1'b0, 2'd0, 3'd0, 0);
      do_req("R4 no match", 8'h10, 1'b0, 2'd0, 3'd0, 0);
      do_req("R10 absent id", 8'h27, 1'b0, 2'd0, 3'd0, 0);
      do_req("R5 flat", 8'h03, 1'b1, 2'd0, 3'd0, 0);
      cfg_fmt[2] = 4'h0; cfg_ld[2] = 8'h35;
      cfg_fmt[3] = 4'h0; cfg_ld[3] = 8'h45;
      cfg_fmt[4] = 4'h6; cfg_ld[4] = 8'hFF;
      do_req("R6 cluster hit", 8'h31, 1'b1, 2'd0, 3'd0, 0);
      do_req("R6 cluster upper miss", 8'h21, 1'b1, 2'd0, 3'd0, 0);
      do_req("R7 odd format", 8'h10, 1'b1, 2'd0, 3'd0, 0);
      do_req("R8 self", 8'h00, 1'b0, 2'd1, 3'd0, 5);
      do_req("R8 R10 absent self", 8'h00, 1'b0, 2'd1, 3'd0, 7);
      do_req("R8 all", 8'h00, 1'b0, 2'd2, 3'd0, 5);
      do_req("R8 others", 8'h00, 1'b0, 2'd3, 3'd0, 0);
      do_req("R9 lowpri others", 8'h00, 1'b0, 2'd3, 3'b001, 0);
      do_req("R9 lowpri empty", 8'h11, 1'b0, 2'd0, 3'b001, 0);

      for (int k = 0; k < 600; k++) begin
         logic [7:0] d;
         logic lg;
         int pick;
         if (k % 8 == 0) rand_cfg();
         lg = 1'($urandom);
         pick = int'($urandom % N);
         case ($urandom % 4)
            0: d = 8'($urandom);
            1: d = lg ? cfg_ld[pick] : 8'hFF;
            default: d = lg ? cfg_ld[pick] : cfg_id[pick];
         endcase
         do_req(lg ? "R5 R6 R7 R9 R10 random logical" : "R3 R4 R8 R9 R10 random physical",
                d, lg, ($urandom % 2) ? 2'd0 : 2'($urandom),
                ($urandom % 4 == 0) ? 3'b001 : 3'($urandom), int'($urandom % N));
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule